// File: doc/BRIEF.md
# Privilege-Aware Exception Vector Generator

This block works out where the processor fetches from when an exception is taken. Each cycle it can accept one exception request (a 3-bit exception code), one trap request for a sensitive operation, and one access to its configuration registers. It considers these against the current mode (user, kernel, monitor or hypervisor) and the security state. From that it chooses the target mode and security state, and it forms the handler address from the right vector base.

It holds three programmable vector bases and a control register. The first base serves the secure monitor. The second serves the hypervisor. The third serves non-secure kernel and user code. The control register holds the hypervisor enable bit. Secure kernel and user exceptions use a fixed base parameter. Each register has its own rule about which modes may access it. An access from a mode that is not allowed is turned into an undefined-instruction exception. When a sensitive operation traps into the hypervisor, the block captures a syndrome word that the hypervisor later reads. All results are registered and appear one clock after the request.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset, `vec_valid_o`, `rd_valid_o` and `syn_o` are low or zero. All three bases and the control register read back as zero, so the hypervisor is disabled.
- R2: The vector address is the chosen base with bits [4:0] replaced by the offset. The offset is four times the exception code: code 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 hypervisor call (0x14), 6 IRQ, 7 FIQ.
- R3: Register select 0 (monitor base) can be read or written only in monitor mode (`mode_i`=2). Any other mode leaves it unchanged and raises an undefined exception (offset 0x04).
- R4: Register select 1 (hypervisor base) can be accessed only from monitor mode or hypervisor mode (`mode_i`=3). Any other mode leaves it unchanged and raises an undefined exception.
- R5: Register select 2 (non-secure kernel base) can be accessed from any mode except user (`mode_i`=0). An access from user mode leaves it unchanged and raises an undefined exception.
- R6: Register select 3 is the control register, with bit 0 as the hypervisor enable. Only monitor mode may access it. An access from any other mode is refused and raises an undefined exception.
- R7: A hypervisor call from non-secure kernel mode, or from hypervisor mode, with the hypervisor enabled targets hypervisor mode (non-secure). It fetches from the hypervisor base at offset 0x14.
- R8: A hypervisor call in any other case is handled as an undefined exception. This covers the hypervisor being disabled, a secure caller, and a user-mode caller.
- R9: A trap request from non-secure kernel mode with the hypervisor enabled targets hypervisor mode at hypervisor base + 0x14, and latches `trap_syn_i` into `syn_o`. In any other case the trap produces no exception and `syn_o` keeps its value.
- R10: Exceptions other than reset and a granted hypervisor call are taken as follows. From user or kernel mode they go to kernel mode in the same security state, using `SEC_VBASE` when secure and the non-secure kernel base otherwise. From monitor mode they stay in monitor mode, which is secure, and use the monitor base. From hypervisor mode they stay in hypervisor mode and use the hypervisor base.
- R11: All outputs are due one cycle after the request. An explicit exception request wins over a trap, which is then dropped without latching a syndrome. A trap wins over an access fault. A cycle with no request gives `vec_valid_o` low.
- R12: A reset exception (code 0) always targets secure kernel mode at `SEC_VBASE` with offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Current mode: 0 user, 1 kernel, 2 monitor, 3 hypervisor |
| sec_i | input | 1 | Current security state, 1 = secure |
| exc_valid_i | input | 1 | Exception request |
| exc_code_i | input | 3 | Exception code (offset / 4) |
| trap_valid_i | input | 1 | Sensitive-operation trap request |
| trap_syn_i | input | SYN_W | Syndrome word for the trap |
| acc_valid_i | input | 1 | Register access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | Register select: 0 monitor base, 1 hypervisor base, 2 non-secure kernel base, 3 control |
| acc_wdata_i | input | ADDR_W | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | ADDR_W | Read data |
| vec_valid_o | output | 1 | Exception is being taken |
| vec_addr_o | output | ADDR_W | Handler fetch address |
| tgt_mode_o | output | 2 | Target mode |
| tgt_sec_o | output | 1 | Target security state |
| syn_o | output | SYN_W | Latched trap syndrome |

## Verification
Every result (vector, target mode and state, read data, syndrome) is registered once. It therefore belongs to the clock edge that samples the request and can be read after that edge. The bench drives each request at a falling edge and samples all outputs at the next falling edge. It computes the expected values from register shadows as they were before that edge. A register write first affects the vector base on the following request, and the bench updates its shadows only after checking.

// File: rtl/evg_pkg.sv
package evg_pkg;
  localparam int OFF_W = 5;

  typedef enum logic [1:0] {
    MD_USR = 2'd0,
    MD_KRN = 2'd1,
    MD_MON = 2'd2,
    MD_HYP = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_UND  = 3'd1,
    EX_SVC  = 3'd2,
    EX_PABT = 3'd3,
    EX_DABT = 3'd4,
    EX_HVC  = 3'd5,
    EX_IRQ  = 3'd6,
    EX_FIQ  = 3'd7
  } exc_e;

  typedef enum logic [1:0] {
    SEL_MON = 2'd0,
    SEL_HYP = 2'd1,
    SEL_NSK = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  localparam int NUM_BASE = 3;
endpackage

// File: rtl/evg_access_check.sv
module evg_access_check
  import evg_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] sel_i,
  output logic       allow_o
);
  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_MON: allow_o = (mode_i == MD_MON);
      SEL_HYP: allow_o = (mode_i == MD_MON) || (mode_i == MD_HYP);
      SEL_NSK: allow_o = (mode_i != MD_USR);
      default: allow_o = (mode_i == MD_MON);
    endcase
  end
endmodule

// File: rtl/evg_base_regs.sv
module evg_base_regs
  import evg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [1:0]                        sel_i,
  input  logic [ADDR_W-1:0]                 wdata_i,
  output logic [NUM_BASE-1:0][ADDR_W-1:0]   base_o,
  output logic                              hyp_en_o,
  output logic [ADDR_W-1:0]                 rdata_o
);
  logic hyp_en_q;

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= '0;
      else if (wr_en_i && (sel_i == 2'(g)))      q <= wdata_i;
    end
    assign base_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             hyp_en_q <= 1'b0;
    else if (wr_en_i && (sel_i == SEL_CTL))  hyp_en_q <= wdata_i[0];
  end

  assign hyp_en_o = hyp_en_q;

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_MON: rdata_o = base_o[0];
      SEL_HYP: rdata_o = base_o[1];
      SEL_NSK: rdata_o = base_o[2];
      default: rdata_o = {{(ADDR_W-1){1'b0}}, hyp_en_q};
    endcase
  end
endmodule

// File: rtl/evg_target.sv
module evg_target
  import evg_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] SEC_VBASE = 32'hFFFF_0000,
  localparam int         HI_W      = ADDR_W - OFF_W
) (
  input  logic [2:0]      code_i,
  input  logic            trap_i,
  input  logic [1:0]      mode_i,
  input  logic            sec_i,
  input  logic            hyp_en_i,
  input  logic [HI_W-1:0] mon_hi_i,
  input  logic [HI_W-1:0] hyp_hi_i,
  input  logic [HI_W-1:0] nsk_hi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]      mode_o,
  output logic            sec_o
);
  localparam logic [ADDR_W-1:0] SEC_FULL = ADDR_W'(SEC_VBASE);
  localparam logic [HI_W-1:0]   SEC_HI   = SEC_FULL[ADDR_W-1:OFF_W];

  exc_e            eff;
  logic            hvc_ok;
  logic [HI_W-1:0] base_hi;
  logic [OFF_W-1:0] off;

  always_comb begin
    hvc_ok = hyp_en_i && !sec_i && ((mode_i == MD_KRN) || (mode_i == MD_HYP));
    eff    = exc_e'(code_i);
    if ((eff == EX_HVC) && !hvc_ok) eff = EX_UND;

    off     = {eff, 2'b00};
    base_hi = SEC_HI;
    mode_o  = MD_KRN;
    sec_o   = 1'b1;

    if (trap_i || (eff == EX_HVC)) begin
      mode_o  = MD_HYP;
      sec_o   = 1'b0;
      base_hi = hyp_hi_i;
      off     = {EX_HVC, 2'b00};
    end else if (eff == EX_RST) begin
      mode_o  = MD_KRN;
      sec_o   = 1'b1;
      base_hi = SEC_HI;
    end else begin
      unique case (mode_e'(mode_i))
        MD_MON: begin mode_o = MD_MON; sec_o = 1'b1; base_hi = mon_hi_i; end
        MD_HYP: begin mode_o = MD_HYP; sec_o = 1'b0; base_hi = hyp_hi_i; end
        default: begin
          mode_o  = MD_KRN;
          sec_o   = sec_i;
          base_hi = sec_i ? SEC_HI : nsk_hi_i;
        end
      endcase
    end
    addr_o = {base_hi, off};
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import evg_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          SYN_W     = 16,
  parameter logic [31:0] SEC_VBASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              sec_i,
  input  logic              exc_valid_i,
  input  logic [2:0]        exc_code_i,
  input  logic              trap_valid_i,
  input  logic [SYN_W-1:0]  trap_syn_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_sel_i,
  input  logic [ADDR_W-1:0] acc_wdata_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        tgt_mode_o,
  output logic              tgt_sec_o,
  output logic [SYN_W-1:0]  syn_o
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic                            allow, acc_ok, fault, trap_take, req_any;
  logic [NUM_BASE-1:0][ADDR_W-1:0] base;
  logic                            hyp_en;
  logic [ADDR_W-1:0]               rdata, addr_d;
  logic [2:0]                      code_d;
  logic                            trap_d, sec_d;
  logic [1:0]                      mode_d;

  evg_access_check u_acc (
    .mode_i  (mode_i),
    .sel_i   (acc_sel_i),
    .allow_o (allow)
  );

  assign acc_ok    = acc_valid_i && allow;
  assign fault     = acc_valid_i && !allow;
  assign trap_take = trap_valid_i && hyp_en && !sec_i && (mode_i == MD_KRN);
  assign req_any   = exc_valid_i || trap_take || fault;

  evg_base_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (acc_ok && acc_write_i),
    .sel_i    (acc_sel_i),
    .wdata_i  (acc_wdata_i),
    .base_o   (base),
    .hyp_en_o (hyp_en),
    .rdata_o  (rdata)
  );

  // explicit exception > trap > access fault
  always_comb begin
    trap_d = 1'b0;
    code_d = EX_UND;
    if (exc_valid_i)    code_d = exc_code_i;
    else if (trap_take) trap_d = 1'b1;
  end

  evg_target #(.ADDR_W(ADDR_W), .SEC_VBASE(SEC_VBASE)) u_tgt (
    .code_i   (code_d),
    .trap_i   (trap_d),
    .mode_i   (mode_i),
    .sec_i    (sec_i),
    .hyp_en_i (hyp_en),
    .mon_hi_i (base[0][ADDR_W-1:OFF_W]),
    .hyp_hi_i (base[1][ADDR_W-1:OFF_W]),
    .nsk_hi_i (base[2][ADDR_W-1:OFF_W]),
    .addr_o   (addr_d),
    .mode_o   (mode_d),
    .sec_o    (sec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_addr_o  <= '0;
      tgt_mode_o  <= MD_USR;
      tgt_sec_o   <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      syn_o       <= '0;
    end else begin
      vec_valid_o <= req_any;
      if (req_any) begin
        vec_addr_o <= addr_d;
        tgt_mode_o <= mode_d;
        tgt_sec_o  <= sec_d;
      end
      rd_valid_o <= acc_ok && !acc_write_i;
      if (acc_ok && !acc_write_i) rd_data_o <= rdata;
      if (trap_d) syn_o <= trap_syn_i;
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/evg_checker.sv
module evg_checker
  import evg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              sec_i,
  input logic              exc_valid_i,
  input logic [2:0]        exc_code_i,
  input logic              trap_valid_i,
  input logic [SYN_W-1:0]  trap_syn_i,
  input logic              acc_valid_i,
  input logic [1:0]        acc_sel_i,
  input logic              vec_valid_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [1:0]        tgt_mode_o,
  input logic              tgt_sec_o,
  input logic [SYN_W-1:0]  syn_o,
  input logic              hyp_en
);
  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_valid_i || trap_valid_i || acc_valid_i) |=> !vec_valid_o);

  assert_hvc_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_code_i == EX_HVC && hyp_en && !sec_i && mode_i == MD_KRN)
    |=> (vec_valid_o && tgt_mode_o == MD_HYP && !tgt_sec_o && vec_addr_o[4:0] == 5'h14));

  assert_hvc_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_code_i == EX_HVC && !hyp_en)
    |=> (vec_valid_o && vec_addr_o[4:0] == 5'h04 && tgt_mode_o != MD_HYP));

  assert_syn_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !exc_valid_i && hyp_en && !sec_i && mode_i == MD_KRN)
    |=> (syn_o == $past(trap_syn_i)));

  assert_syn_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> $stable(syn_o));

  assert_mon_deny_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_sel_i == SEL_MON && mode_i != MD_MON && !exc_valid_i && !trap_valid_i)
    |=> (vec_valid_o && vec_addr_o[4:0] == 5'h04));

  assert_mon_secure_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && tgt_mode_o == MD_MON) |-> tgt_sec_o);

  assert_hyp_nonsec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && tgt_mode_o == MD_HYP) |-> !tgt_sec_o);
endmodule

bind exc_vector_gen evg_checker #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_evg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .sec_i        (sec_i),
  .exc_valid_i  (exc_valid_i),
  .exc_code_i   (exc_code_i),
  .trap_valid_i (trap_valid_i),
  .trap_syn_i   (trap_syn_i),
  .acc_valid_i  (acc_valid_i),
  .acc_sel_i    (acc_sel_i),
  .vec_valid_o  (vec_valid_o),
  .vec_addr_o   (vec_addr_o),
  .tgt_mode_o   (tgt_mode_o),
  .tgt_sec_o    (tgt_sec_o),
  .syn_o        (syn_o),
  .hyp_en       (hyp_en)
);

// File: tb/exc_vector_gen_tb_top.sv
module exc_vector_gen_tb_top;
  localparam int          ADDR_W = 32;
  localparam int          SYN_W  = 16;
  localparam logic [31:0] SECB   = 32'hFFFF_0000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        mode_i = '0;
  logic              sec_i = 1'b0;
  logic              exc_valid_i = 1'b0;
  logic [2:0]        exc_code_i = '0;
  logic              trap_valid_i = 1'b0;
  logic [SYN_W-1:0]  trap_syn_i = '0;
  logic              acc_valid_i = 1'b0;
  logic              acc_write_i = 1'b0;
  logic [1:0]        acc_sel_i = '0;
  logic [ADDR_W-1:0] acc_wdata_i = '0;
  logic              rd_valid_o, vec_valid_o, tgt_sec_o;
  logic [ADDR_W-1:0] rd_data_o, vec_addr_o;
  logic [1:0]        tgt_mode_o;
  logic [SYN_W-1:0]  syn_o;

  int n_chk = 0;
  int n_bad = 0;

  // shadow state
  logic [31:0] m_mon = '0, m_hyp = '0, m_nsk = '0;
  logic        m_hen = 1'b0;
  logic [15:0] m_syn = '0;

  always #10 clk_i = ~clk_i;

  exc_vector_gen #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .SEC_VBASE(SECB)) dut_i (
    .clk_i, .rst_ni, .mode_i, .sec_i, .exc_valid_i, .exc_code_i,
    .trap_valid_i, .trap_syn_i, .acc_valid_i, .acc_write_i, .acc_sel_i,
    .acc_wdata_i, .rd_valid_o, .rd_data_o, .vec_valid_o, .vec_addr_o,
    .tgt_mode_o, .tgt_sec_o, .syn_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [1:0] sel, input logic [1:0] md);
    case (sel)
      2'd0:    return md == 2'd2;
      2'd1:    return md == 2'd2 || md == 2'd3;
      2'd2:    return md != 2'd0;
      default: return md == 2'd2;
    endcase
  endfunction

  function automatic logic [31:0] shadow_rd(input logic [1:0] sel);
    case (sel)
      2'd0:    return m_mon;
      2'd1:    return m_hyp;
      2'd2:    return m_nsk;
      default: return {31'd0, m_hen};
    endcase
  endfunction

  task automatic predict(input logic [2:0] ec, input logic tr, input logic [1:0] md, input logic sc,
                         output logic [31:0] a, output logic [1:0] m, output logic s);
    logic [2:0]  code;
    logic [31:0] b;
    code = ec;
    if (!tr && ec == 3'd5 && !(m_hen && !sc && (md == 2'd1 || md == 2'd3))) code = 3'd1;
    if (tr || code == 3'd5) begin
      m = 2'd3; s = 1'b0; a = (m_hyp & ~32'h1F) | 32'h14;
    end else if (code == 3'd0) begin
      m = 2'd1; s = 1'b1; a = SECB & ~32'h1F;
    end else begin
      case (md)
        2'd2:    begin m = 2'd2; s = 1'b1; b = m_mon; end
        2'd3:    begin m = 2'd3; s = 1'b0; b = m_hyp; end
        default: begin m = 2'd1; s = sc;   b = sc ? SECB : m_nsk; end
      endcase
      a = (b & ~32'h1F) | {27'd0, code, 2'b00};
    end
  endtask

  task automatic op(input string req, input logic [1:0] md, input logic sc,
                    input logic ev, input logic [2:0] ec,
                    input logic tv, input logic [15:0] ts,
                    input logic av, input logic aw, input logic [1:0] asel, input logic [31:0] ad);
    logic        ok, tt, flt, e_v, e_rv, e_s;
    logic [31:0] e_a, e_rd;
    logic [1:0]  e_m;
    logic [15:0] e_syn;
    ok  = allowed(asel, md);
    tt  = tv && m_hen && !sc && md == 2'd1;
    flt = av && !ok;
    e_v = ev || tt || flt;
    if (ev)      predict(ec, 1'b0, md, sc, e_a, e_m, e_s);
    else if (tt) predict(3'd0, 1'b1, md, sc, e_a, e_m, e_s);
    else         predict(3'd1, 1'b0, md, sc, e_a, e_m, e_s);
    e_rv  = av && ok && !aw;
    e_rd  = shadow_rd(asel);
    e_syn = (!ev && tt) ? ts : m_syn;

    mode_i = md; sec_i = sc; exc_valid_i = ev; exc_code_i = ec;
    trap_valid_i = tv; trap_syn_i = ts; acc_valid_i = av; acc_write_i = aw;
    acc_sel_i = asel; acc_wdata_i = ad;
    @(negedge clk_i);

    chk(req, "vec_valid", {31'd0, vec_valid_o}, {31'd0, e_v});
    if (e_v) begin
      chk(req, "vec_addr", vec_addr_o, e_a);
      chk(req, "tgt_mode", {30'd0, tgt_mode_o}, {30'd0, e_m});
      chk(req, "tgt_sec", {31'd0, tgt_sec_o}, {31'd0, e_s});
    end
    chk(req, "rd_valid", {31'd0, rd_valid_o}, {31'd0, e_rv});
    if (e_rv) chk(req, "rd_data", rd_data_o, e_rd);
    chk(req, "syn", {16'd0, syn_o}, {16'd0, e_syn});

    if (av && ok && aw) begin
      case (asel)
        2'd0: m_mon = ad;
        2'd1: m_hyp = ad;
        2'd2: m_nsk = ad;
        default: m_hen = ad[0];
      endcase
    end
    m_syn = e_syn;
    exc_valid_i = 1'b0; trap_valid_i = 1'b0; acc_valid_i = 1'b0;
  endtask

  task automatic wr(input string req, input logic [1:0] md, input logic sc, input logic [1:0] sel, input logic [31:0] d);
    op(req, md, sc, 1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, sel, d);
  endtask

  task automatic rd(input string req, input logic [1:0] sel);
    op(req, 2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, sel, 32'd0);
  endtask

  task automatic ex(input string req, input logic [1:0] md, input logic sc, input logic [2:0] ec);
    op(req, md, sc, 1'b1, ec, 1'b0, 16'd0, 1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "vec_valid", {31'd0, vec_valid_o}, 32'd0);
    chk("R1", "rd_valid", {31'd0, rd_valid_o}, 32'd0);
    chk("R1", "syn", {16'd0, syn_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) rd("R1", 2'(i));

    // programming from monitor
    wr("R3", 2'd2, 1'b1, 2'd0, 32'h1000_0047);
    wr("R4", 2'd2, 1'b1, 2'd1, 32'h2000_001F);
    wr("R5", 2'd2, 1'b1, 2'd2, 32'h3000_0010);
    for (int i = 0; i < 3; i++) rd("R3", 2'(i));

    // R3: non-monitor access to monitor base
    wr("R3", 2'd1, 1'b0, 2'd0, 32'hDEAD_0000);
    op("R3", 2'd1, 1'b1, 1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 2'd0, 32'd0);
    rd("R3", 2'd0);
    // R5: user access to kernel base
    wr("R5", 2'd0, 1'b0, 2'd2, 32'hBAD0_0000);
    wr("R5", 2'd1, 1'b1, 2'd2, 32'h3000_0100);
    rd("R5", 2'd2);
    // R4: kernel access to hypervisor base
    wr("R4", 2'd1, 1'b0, 2'd1, 32'hBAD1_0000);
    rd("R4", 2'd1);
    // R8: hypervisor call while disabled
    ex("R8", 2'd1, 1'b0, 3'd5);
    // R9: trap while disabled is ignored
    op("R9", 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 16'h1234, 1'b0, 1'b0, 2'd0, 32'd0);
    // R6: control from secure kernel refused, then enable from monitor
    wr("R6", 2'd1, 1'b1, 2'd3, 32'd1);
    rd("R6", 2'd3);
    wr("R6", 2'd2, 1'b1, 2'd3, 32'd1);
    rd("R6", 2'd3);
    // R7: hypervisor call granted
    ex("R7", 2'd1, 1'b0, 3'd5);
    ex("R7", 2'd3, 1'b0, 3'd5);
    // R8: secure and user callers still refused
    ex("R8", 2'd1, 1'b1, 3'd5);
    ex("R8", 2'd0, 1'b0, 3'd5);
    // R9: trap taken, then ignored from user and from secure kernel
    op("R9", 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 16'hBEEF, 1'b0, 1'b0, 2'd0, 32'd0);
    op("R9", 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 16'h5555, 1'b0, 1'b0, 2'd0, 32'd0);
    op("R9", 2'd1, 1'b1, 1'b0, 3'd0, 1'b1, 16'h6666, 1'b0, 1'b0, 2'd0, 32'd0);
    // R4: hypervisor mode may write its base but not the monitor base
    wr("R4", 2'd3, 1'b0, 2'd1, 32'h2200_0000);
    rd("R4", 2'd1);
    wr("R3", 2'd3, 1'b0, 2'd0, 32'hBAD2_0000);
    // R2: every code from non-secure user
    for (int c = 1; c < 8; c++) ex("R2", 2'd0, 1'b0, 3'(c));
    // R12: reset exception from several modes
    ex("R12", 2'd0, 1'b0, 3'd0);
    ex("R12", 2'd3, 1'b0, 3'd0);
    // R10: monitor, secure user, hypervisor
    ex("R10", 2'd2, 1'b1, 3'd6);
    ex("R10", 2'd0, 1'b1, 3'd2);
    ex("R10", 2'd3, 1'b0, 3'd4);
    // R11: exception beats trap (no syndrome) and beats an access fault
    op("R11", 2'd1, 1'b0, 1'b1, 3'd7, 1'b1, 16'hAAAA, 1'b0, 1'b0, 2'd0, 32'd0);
    op("R11", 2'd0, 1'b0, 1'b1, 3'd3, 1'b0, 16'd0, 1'b1, 1'b1, 2'd0, 32'hBAD3_0000);
    op("R11", 2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 16'hC0DE, 1'b1, 1'b1, 2'd0, 32'hBAD4_0000);
    rd("R11", 2'd0);

    for (int n = 0; n < 800; n++) begin
      logic        sc;
      logic [1:0]  md;
      sc = 1'($urandom);
      if (sc) md = 2'($urandom % 3);
      else if (m_hen) md = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 2);
      else md = 2'($urandom % 2);
      op("R11", md, sc, ($urandom % 4) == 0, 3'($urandom), ($urandom % 4) == 0, 16'($urandom),
         ($urandom % 3) == 0, 1'($urandom), 2'($urandom), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule